// File: doc/BRIEF.md
# Flash Query-Mode Command Responder

This block holds the command-mode state of a parallel NOR flash that can be asked, over its ordinary read/write bus, to identify itself. It sits behind a simple synchronous bus with chip select, write strobe, read strobe, a width select, an address and a 16-bit data path. Bus writes are examined for three commands: a query entry code, a single-cycle identification entry code and a reset code. Reads are then answered from one of three places, chosen by the current mode: the external array data input, a small identification-code lookup, or the query lookup with its identification string, timing, geometry and extended capability words.

In byte mode the address on the bus counts bytes. The block halves it before any command or lookup decode, ignores its lowest bit, and returns lookup data on the low eight data bits with the upper byte at zero. Reads are combinational on the address. Mode changes take effect at the clock edge that samples a write cycle.

Top module: `cfi_query_responder`

## Requirements
- R1: A write cycle with data low byte 98h at word address 55h while in array mode moves the block to query mode on the next clock edge. The same data at any other address leaves the mode unchanged.
- R2: The same query command written while in identification mode also moves the block to query mode.
- R3: A write cycle with data low byte F0h, at any address, returns the block to array mode from query mode or from identification mode.
- R4: In query mode a read at a word address outside 10h..3Ch and 40h..50h returns 0000h with `rd_invalid` = 1. Inside those ranges `rd_invalid` is 0. `rd_invalid` is 0 in every other mode.
- R5: In query mode every write cycle other than the reset command is ignored. The mode stays query, and later reads return the same query data.
- R6: With `byte_sel` = 1 the word address used for command and lookup decode is the bus address shifted right by one. Byte address 2N and byte address 2N+1 both map to word address N. Query entry therefore happens at byte address AAh or ABh.
- R7: Query lookup contents: 10h/11h/12h = 0051h/0052h/0059h, 40h/41h/42h = 0050h/0052h/0049h, and the remaining words hold the timing, geometry and capability table given in the bench model. Words not listed read 0000h.
- R8: In identification mode word address 00h returns 0001h, 01h returns 227Eh, 0Eh returns 2248h and 0Fh returns 2201h. Every other word address returns 0000h.
- R9: With `byte_sel` = 1, reads in identification or query mode carry the low byte of the word on bits 7..0 and zero on bits 15..8.
- R10: While `rst_n` is low at a clock edge, the mode becomes array, whatever the mode was before.
- R11: In array mode a read returns `array_rdata` unchanged, in either width. When `cs` and `rd` are not both high, `rdata` is 0000h.
- R12: A write cycle with data low byte 90h in array mode moves the block to identification mode.
- R13: `mode` encodes array as 0, identification as 1 and query as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe, sampled at the clock edge |
| rd | input | 1 | Read strobe |
| byte_sel | input | 1 | 1 = byte addressing on an 8-bit data lane, 0 = word addressing |
| addr | input | ADDR_W | Bus address, in words or bytes depending on `byte_sel` |
| wdata | input | 16 | Write data; commands are taken from bits 7..0 |
| array_rdata | input | 16 | Data from the memory array, used in array mode |
| rdata | output | 16 | Read data |
| rd_invalid | output | 1 | High while a query-mode read falls outside the defined table |
| mode | output | 2 | Current mode: 0 array, 1 identification, 2 query |

## Verification
The query lookup is swept over every word address from 00h to 5Fh, plus one address with upper bits set. This covers both valid ranges, the gap between them and the edges on either side, so a misplaced range bound or a wrong table word stands out. The same sweep is repeated in byte mode over every even and odd byte address. That run separates correct halving from an unshifted decode, and checks that the upper byte is cleared. The identification lookup is swept the same way. Commands are written at the right address, at neighbouring addresses, at byte addresses and in every mode. This tells a decode that checks the address apart from one that does not, and shows whether a refused write in query mode leaves mode and data alone.

// File: rtl/cfi_query_responder.sv
module cfi_query_responder #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic              byte_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic [15:0]       array_rdata,
  output logic [15:0]       rdata,
  output logic              rd_invalid,
  output logic [1:0]        mode
);
  localparam logic [1:0] M_ARRAY = 2'd0, M_IDENT = 2'd1, M_QUERY = 2'd2;
  localparam int HI_W = ADDR_W - 8;

  logic [1:0]        mode_q;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        idx;
  logic              upper_zero;
  logic [15:0]       q_word, id_word, lane;
  logic              q_hit;

  assign waddr      = byte_sel ? (addr >> 1) : addr;
  assign idx        = waddr[7:0];
  assign upper_zero = (waddr[ADDR_W-1:8] == HI_W'(0));

  wire wr_cyc    = cs & wr;
  wire cmd_reset = wr_cyc && (wdata[7:0] == 8'hF0);
  wire cmd_query = wr_cyc && (wdata[7:0] == 8'h98) && upper_zero && (idx == 8'h55);
  wire cmd_ident = wr_cyc && (wdata[7:0] == 8'h90);
  wire rd_cyc    = cs & rd;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= M_ARRAY;
    else begin
      case (mode_q)
        M_ARRAY: if (cmd_query) mode_q <= M_QUERY;
                 else if (cmd_ident) mode_q <= M_IDENT;
        M_IDENT: if (cmd_reset) mode_q <= M_ARRAY;
                 else if (cmd_query) mode_q <= M_QUERY;
        M_QUERY: if (cmd_reset) mode_q <= M_ARRAY;
        default: mode_q <= M_ARRAY;
      endcase
    end
  end

  always_comb begin
    q_hit  = upper_zero && ((idx >= 8'h10 && idx <= 8'h3C) || (idx >= 8'h40 && idx <= 8'h50));
    q_word = 16'h0000;
    case (idx)
      8'h10: q_word = 16'h0051;  8'h11: q_word = 16'h0052;  8'h12: q_word = 16'h0059;
      8'h13: q_word = 16'h0002;  8'h15: q_word = 16'h0040;
      8'h1B: q_word = 16'h0027;  8'h1C: q_word = 16'h0036;  8'h1F: q_word = 16'h0006;
      8'h20: q_word = 16'h0006;  8'h21: q_word = 16'h0009;  8'h22: q_word = 16'h0013;
      8'h23: q_word = 16'h0003;  8'h24: q_word = 16'h0005;  8'h25: q_word = 16'h0003;
      8'h26: q_word = 16'h0002;  8'h27: q_word = 16'h001B;  8'h28: q_word = 16'h0002;
      8'h2A: q_word = 16'h0006;  8'h2C: q_word = 16'h0001;  8'h2D: q_word = 16'h00FF;
      8'h2E: q_word = 16'h0003;  8'h30: q_word = 16'h0002;
      8'h40: q_word = 16'h0050;  8'h41: q_word = 16'h0052;  8'h42: q_word = 16'h0049;
      8'h43: q_word = 16'h0031;  8'h44: q_word = 16'h0033;  8'h45: q_word = 16'h0014;
      8'h46: q_word = 16'h0002;  8'h47: q_word = 16'h0001;  8'h49: q_word = 16'h0008;
      8'h4C: q_word = 16'h0002;  8'h4D: q_word = 16'h00B5;  8'h4E: q_word = 16'h00C5;
      8'h4F: q_word = 16'h0005;  8'h50: q_word = 16'h0001;
      default: q_word = 16'h0000;
    endcase
    if (!q_hit) q_word = 16'h0000;

    id_word = 16'h0000;
    if (upper_zero) begin
      case (idx)
        8'h00: id_word = 16'h0001;
        8'h01: id_word = 16'h227E;
        8'h0E: id_word = 16'h2248;
        8'h0F: id_word = 16'h2201;
        default: id_word = 16'h0000;
      endcase
    end
  end

  always_comb begin
    lane = (mode_q == M_QUERY) ? q_word : id_word;
    if (byte_sel) lane = {8'h00, lane[7:0]};
  end

  assign rdata      = !rd_cyc ? 16'h0000 : (mode_q == M_ARRAY) ? array_rdata : lane;
  assign rd_invalid = rd_cyc && (mode_q == M_QUERY) && !q_hit;
  assign mode       = mode_q;

  p_query_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ARRAY && cmd_query) |=> (mode == M_QUERY));
  p_ident_to_query_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDENT && cmd_query && !cmd_reset) |=> (mode == M_QUERY));
  p_reset_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ARRAY && cmd_reset) |=> (mode == M_ARRAY));
  p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_invalid |-> (rdata == 16'h0000 && mode == M_QUERY));
  p_query_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_QUERY && !cmd_reset) |=> (mode == M_QUERY));
  p_upper_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_sel && mode != M_ARRAY) |-> (rdata[15:8] == 8'h00));
  p_array_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ARRAY && cs && rd) |-> (rdata == array_rdata));
  p_mode_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

// File: tb/cfi_query_responder_tb.sv
`timescale 1ns/1ps
module cfi_query_responder_tb;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, wr = 1'b0, rd = 1'b0, byte_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, array_rdata = '0, rdata;
  logic rd_invalid;
  logic [1:0] mode;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfi_query_responder #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .byte_sel(byte_sel),
    .addr(addr), .wdata(wdata), .array_rdata(array_rdata),
    .rdata(rdata), .rd_invalid(rd_invalid), .mode(mode));

  function automatic logic [16:0] q_model(input int w);
    logic [15:0] d;
    logic h;
    h = (w >= 'h10 && w <= 'h3C) || (w >= 'h40 && w <= 'h50);
    case (w)
      'h10: d = 'h51; 'h11: d = 'h52; 'h12: d = 'h59; 'h13: d = 'h02; 'h15: d = 'h40;
      'h1B: d = 'h27; 'h1C: d = 'h36; 'h1F: d = 'h06; 'h20: d = 'h06; 'h21: d = 'h09;
      'h22: d = 'h13; 'h23: d = 'h03; 'h24: d = 'h05; 'h25: d = 'h03; 'h26: d = 'h02;
      'h27: d = 'h1B; 'h28: d = 'h02; 'h2A: d = 'h06; 'h2C: d = 'h01; 'h2D: d = 'hFF;
      'h2E: d = 'h03; 'h30: d = 'h02;
      'h40: d = 'h50; 'h41: d = 'h52; 'h42: d = 'h49; 'h43: d = 'h31; 'h44: d = 'h33;
      'h45: d = 'h14; 'h46: d = 'h02; 'h47: d = 'h01; 'h49: d = 'h08; 'h4C: d = 'h02;
      'h4D: d = 'hB5; 'h4E: d = 'hC5; 'h4F: d = 'h05; 'h50: d = 'h01;
      default: d = 0;
    endcase
    return {h, h ? d : 16'h0};
  endfunction

  function automatic logic [15:0] id_model(input int w);
    case (w)
      'h00: return 16'h0001;
      'h01: return 16'h227E;
      'h0E: return 16'h2248;
      'h0F: return 16'h2201;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d, input bit bm);
    @(negedge clk);
    byte_sel = bm; addr = AW'(a); wdata = 16'(d); cs = 1; wr = 1;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic bus_read(input int a, input bit bm, output logic [15:0] d, output logic inv);
    @(negedge clk);
    byte_sel = bm; addr = AW'(a); cs = 1; rd = 1;
    #1;
    d = rdata; inv = rd_invalid;
    cs = 0; rd = 0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic inv;
    logic [16:0] m;
    repeat (3) @(negedge clk);
    chk(mode, 0, "R10 reset mode");
    chk(rdata, 0, "R11 idle rdata");
    rst_n = 1;
    // R11 array passthrough in both widths
    array_rdata = 16'hA5C3; bus_read('h10, 0, d, inv); chk(d, 'hA5C3, "R11 array word");
    array_rdata = 16'h1234; bus_read('h21, 1, d, inv); chk(d, 'h1234, "R11 array byte");
    chk(inv, 0, "R4 no invalid in array");
    // R1 address decode
    bus_write('h54, 'h98, 0); chk(mode, 0, "R1 wrong address");
    bus_write('h56, 'h98, 0); chk(mode, 0, "R1 wrong address");
    bus_write('h55, 'h98, 0); chk(mode, 2, "R1 entry R13");
    // R4 R7 word sweep
    for (int w = 0; w < 'h60; w++) begin
      bus_read(w, 0, d, inv); m = q_model(w);
      chk(d, m[15:0], "R7 query word");
      chk(inv, !m[16], "R4 invalid flag");
    end
    bus_read('h110, 0, d, inv); chk(inv, 1, "R4 upper bits");
    chk(d, 0, "R4 upper bits data");
    // R6 R9 byte sweep
    for (int b = 0; b < 'hC0; b++) begin
      bus_read(b, 1, d, inv); m = q_model(b / 2);
      chk(d, {8'h00, m[7:0]}, "R6 R9 query byte");
      chk(inv, !m[16], "R6 byte invalid");
    end
    // R5 refused writes
    bus_write('h00, 'h90, 0); chk(mode, 2, "R5 ident cmd refused");
    bus_write('h10, 'h00, 0); chk(mode, 2, "R5 data write refused");
    bus_write('h55, 'h98, 0); chk(mode, 2, "R5 reentry");
    bus_read('h10, 0, d, inv); chk(d, 'h0051, "R5 data kept");
    // R3 exit
    bus_write('h123, 'hF0, 0); chk(mode, 0, "R3 exit query");
    // R12 ident entry, R8 sweep
    bus_write('h7, 'h90, 0); chk(mode, 1, "R12 ident entry R13");
    for (int w = 0; w < 'h20; w++) begin
      bus_read(w, 0, d, inv); chk(d, id_model(w), "R8 ident word");
      chk(inv, 0, "R4 no invalid ident");
    end
    for (int b = 0; b < 'h40; b++) begin
      bus_read(b, 1, d, inv); chk(d, {8'h00, id_model(b / 2) & 16'hFF}, "R8 R9 ident byte");
    end
    // R2 entry from ident, byte address AB
    bus_write('hAB, 'h98, 1); chk(mode, 2, "R2 R6 ident to query");
    bus_write('h0, 'hF0, 1); chk(mode, 0, "R3 exit byte");
    bus_write('h0, 'h90, 0); bus_write('h3, 'hF0, 0); chk(mode, 0, "R3 exit ident");
    // R6 byte decode of command
    bus_write('h55, 'h98, 1); chk(mode, 0, "R6 byte 55 not entry");
    bus_write('hAA, 'h98, 1); chk(mode, 2, "R6 byte AA entry");
    // R10 reset from query and ident
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    chk(mode, 0, "R10 reset from query");
    bus_write('h0, 'h90, 0);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    chk(mode, 0, "R10 reset from ident");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule